// File: doc/BRIEF.md
# Symmetric-Coefficient Two-Lane FIR Filter

This block filters a sample stream that arrives two samples per clock, with a linear-phase FIR filter whose coefficients are even-symmetric (h(i) = h(N-1-i)). Lane 0 carries the earlier sample of each pair, x(2k), and lane 1 carries the later one, x(2k+1). The two outputs are y(2k) and y(2k+1) of the ordinary convolution y(n) = sum over i of h(i)·x(n-i).

Inside, the pair is split into its sum and its difference. Each feeds a half-length sub-filter: the first has coefficients h(2i)+h(2i+1), and the second has h(2i)-h(2i+1). Because the full filter is symmetric, the first sub-filter is symmetric and the second is antisymmetric. Each is built in transposed form, and every multiplier output serves two mirrored taps. That halves the multiplier count of both sub-filters. A third, plain sub-filter uses the odd-phase coefficients on lane 1. Post-adders form the two outputs with a one-bit arithmetic right shift, and one block of delay supplies the term that crosses from one pair to the next.

The coefficients are a parameter. NTAPS must be a multiple of four and the coefficient set must be symmetric. The pipeline advances only on pairs flagged valid, so gaps in the stream do not disturb the result.

Top module: `fir2p_sym_top`

## Requirements
- R1: While `rst` is high, `out_valid` is 0 and both outputs are 0. All delay state is cleared, so the first pair after reset is filtered as if every earlier sample were zero. For example, `out_y0` = h(0)·x0 and `out_y1` = h(0)·x1 + h(1)·x0.
- R2: For each valid pair (x0 = x(2k), x1 = x(2k+1)), `out_y0` equals y(2k) and `out_y1` equals y(2k+1) of the N-tap convolution. The result is bit-exact and in two's complement.
- R3: `out_valid` is high exactly one clock after a cycle with `in_valid` high, and low after a cycle with `in_valid` low.
- R4: A cycle with `in_valid` low leaves both outputs unchanged and does not advance the filter state. The stream with its gaps removed gives the same results.
- R5: Full-scale inputs of either sign with any valid coefficient set give the exact result without overflow. The output width is DW+CW+clog2(NTAPS)+2 bits.
- R6: A sample on lane 1 contributes to lane 0 of the following valid pair through h(1)-weighted and later odd-phase terms. In particular, a unit impulse on lane 1 shows h(1) on `out_y0` of the next pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair is valid this cycle |
| in_x0 | input | DW | Earlier sample of the pair, signed |
| in_x1 | input | DW | Later sample of the pair, signed |
| out_valid | output | 1 | Output pair is valid |
| out_y0 | output | OW | Filtered earlier sample, signed |
| out_y1 | output | OW | Filtered later sample, signed |

## Verification
The bench drives impulses into each lane on its own. A sign error in the antisymmetric sub-filter's mirrored taps would swap or corrupt the odd-indexed coefficients in the response, and a missing block delay would drop the lane-1 contribution to the next lane-0 output. Runs of the most negative input against the extreme coefficients target the sum path: one bit too few before the halving shift would wrap and flip the sign there. Random traffic with gaps and a reset in mid-stream expose a delay line that advances on idle cycles or survives reset, since either would make later outputs diverge from the gap-free model.

// File: rtl/fir2p_pkg.sv
package fir2p_pkg;
  // Width of every internal and output word: product, tap growth, sign and halving headroom.
  function automatic int word_bits(int dw, int cw, int ntaps);
    return dw + cw + $clog2(ntaps) + 2;
  endfunction
endpackage

// File: rtl/fir2p_preadd.sv
module fir2p_preadd #(
  parameter int DW = 8
) (
  input  logic signed [DW-1:0] x0,
  input  logic signed [DW-1:0] x1,
  output logic signed [DW:0]   sum_o,
  output logic signed [DW:0]   diff_o
);
  logic signed [DW:0] x0e, x1e;
  assign x0e    = {x0[DW-1], x0};
  assign x1e    = {x1[DW-1], x1};
  assign sum_o  = x0e + x1e;
  assign diff_o = x0e - x1e;
endmodule

// File: rtl/fir2p_symtf.sv
// Transposed-form sub-filter with mirrored taps sharing one multiplier.
// ANTI selects negation at the mirrored tap (antisymmetric set).
module fir2p_symtf #(
  parameter int TAPS = 4,
  parameter int UW   = 9,
  parameter int CWS  = 9,
  parameter int AW   = 21,
  parameter bit ANTI = 1'b0,
  localparam int HALF = TAPS / 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic signed [UW-1:0]  u,
  input  logic [HALF*CWS-1:0]   coef_half,
  output logic signed [AW-1:0]  y
);
  logic signed [AW-1:0] ue;
  logic signed [AW-1:0] prod [HALF];
  logic signed [AW-1:0] tap  [TAPS];
  logic signed [AW-1:0] st   [TAPS-1];

  assign ue = AW'(u);

  for (genvar i = 0; i < HALF; i++) begin : g_mul
    logic signed [AW-1:0] ce;
    assign ce      = AW'($signed(coef_half[i*CWS +: CWS]));
    assign prod[i] = ue * ce;
    assign tap[i]  = prod[i];
    if (ANTI) begin : g_neg
      assign tap[TAPS-1-i] = -prod[i];
    end else begin : g_pos
      assign tap[TAPS-1-i] = prod[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < TAPS-1; j++) st[j] <= '0;
    end else if (en) begin
      for (int j = 0; j < TAPS-2; j++) st[j] <= tap[j+1] + st[j+1];
      st[TAPS-2] <= tap[TAPS-1];
    end
  end

  assign y = tap[0] + st[0];
endmodule

// File: rtl/fir2p_tf.sv
// Plain transposed-form sub-filter, one multiplier per tap.
module fir2p_tf #(
  parameter int TAPS = 4,
  parameter int UW   = 8,
  parameter int CWS  = 8,
  parameter int AW   = 21
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic signed [UW-1:0]  u,
  input  logic [TAPS*CWS-1:0]   coef,
  output logic signed [AW-1:0]  y
);
  logic signed [AW-1:0] ue;
  logic signed [AW-1:0] tap [TAPS];
  logic signed [AW-1:0] st  [TAPS-1];

  assign ue = AW'(u);

  for (genvar i = 0; i < TAPS; i++) begin : g_mul
    logic signed [AW-1:0] ce;
    assign ce     = AW'($signed(coef[i*CWS +: CWS]));
    assign tap[i] = ue * ce;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < TAPS-1; j++) st[j] <= '0;
    end else if (en) begin
      for (int j = 0; j < TAPS-2; j++) st[j] <= tap[j+1] + st[j+1];
      st[TAPS-2] <= tap[TAPS-1];
    end
  end

  assign y = tap[0] + st[0];
endmodule

// File: rtl/fir2p_sym_top.sv
module fir2p_sym_top #(
  parameter int DW    = 8,
  parameter int CW    = 8,
  parameter int NTAPS = 8,
  // Coefficient h(j) sits at bits [j*CW +: CW]; the set must be symmetric.
  parameter logic [NTAPS*CW-1:0] COEFS = {8'h80, 8'h07, 8'h7F, 8'h5A,
                                          8'h5A, 8'h7F, 8'h07, 8'h80},
  // Derived width; leave at its default.
  parameter int OW = fir2p_pkg::word_bits(DW, CW, NTAPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_x0,
  input  logic signed [DW-1:0] in_x1,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_y0,
  output logic signed [OW-1:0] out_y1
);
  localparam int M  = NTAPS / 2;   // polyphase length
  localparam int HM = M / 2;       // shared multipliers per symmetric sub-filter
  localparam int CA = CW + 1;      // sum/difference coefficient width
  localparam int UW = DW + 1;      // sum/difference sample width

  function automatic logic signed [CA-1:0] hc(int j);
    return {COEFS[j*CW+CW-1], COEFS[j*CW +: CW]};
  endfunction

  logic [HM*CA-1:0] a_half, b_half;
  logic [M*CW-1:0]  odd_coef;

  always_comb begin
    for (int i = 0; i < HM; i++) begin
      a_half[i*CA +: CA] = hc(2*i) + hc(2*i+1);
      b_half[i*CA +: CA] = hc(2*i) - hc(2*i+1);
    end
    for (int i = 0; i < M; i++) odd_coef[i*CW +: CW] = COEFS[(2*i+1)*CW +: CW];
  end

  logic signed [UW-1:0] s_in, d_in;
  logic signed [OW-1:0] ya, yb, yh;

  fir2p_preadd #(.DW(DW)) u_pre (
    .x0(in_x0), .x1(in_x1), .sum_o(s_in), .diff_o(d_in)
  );

  fir2p_symtf #(.TAPS(M), .UW(UW), .CWS(CA), .AW(OW), .ANTI(1'b0)) u_sum (
    .clk(clk), .rst(rst), .en(in_valid), .u(s_in), .coef_half(a_half), .y(ya)
  );

  fir2p_symtf #(.TAPS(M), .UW(UW), .CWS(CA), .AW(OW), .ANTI(1'b1)) u_dif (
    .clk(clk), .rst(rst), .en(in_valid), .u(d_in), .coef_half(b_half), .y(yb)
  );

  fir2p_tf #(.TAPS(M), .UW(DW), .CWS(CW), .AW(OW)) u_odd (
    .clk(clk), .rst(rst), .en(in_valid), .u(in_x1), .coef(odd_coef), .y(yh)
  );

  logic signed [OW-1:0] half_sum, half_dif, odd_q, y0_c;
  assign half_sum = (ya + yb) >>> 1;   // H0X0 + H1X1, exact (sum is even)
  assign half_dif = (ya - yb) >>> 1;   // H0X1 + H1X0
  assign y0_c     = half_sum - yh + odd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      odd_q     <= '0;
      out_valid <= 1'b0;
      out_y0    <= '0;
      out_y1    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        odd_q  <= yh;
        out_y0 <= y0_c;
        out_y1 <= half_dif;
      end
    end
  end
endmodule

// File: rtl/fir2p_sym_chk.sv
module fir2p_sym_chk #(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int OW = 21,
  parameter logic [2*CW-1:0] LOW2 = '0
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_x0,
  input logic signed [DW-1:0] in_x1,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_y0,
  input logic signed [OW-1:0] out_y1
);
  logic fresh;
  logic signed [OW-1:0] c0, c1, e0, e1;

  always_ff @(posedge clk) begin
    if (rst) fresh <= 1'b1;
    else if (in_valid) fresh <= 1'b0;
  end

  assign c0 = OW'($signed(LOW2[CW-1:0]));
  assign c1 = OW'($signed(LOW2[2*CW-1:CW]));
  assign e0 = OW'(in_x0) * c0;
  assign e1 = OW'(in_x1) * c0 + OW'(in_x0) * c1;

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && out_y0 == '0 && out_y1 == '0));
  // R1
  a_r1_fresh_start: assert property (@(posedge clk) disable iff (rst)
    fresh && in_valid |=> (out_y0 == $past(e0) && out_y1 == $past(e1)));
  // R3
  a_r3_valid_follow: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R3
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R4
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_y0) && $stable(out_y1)));
endmodule

bind fir2p_sym_top fir2p_sym_chk #(
  .DW(DW), .CW(CW), .OW(OW), .LOW2(COEFS[2*CW-1:0])
) u_chk (.*);

// File: tb/sim_fir2p_sym_top.sv
module sim_fir2p_sym_top;
  localparam int NT = 8;
  localparam int OW = 21;
  localparam int H[NT] = '{-128, 7, 127, 90, 90, 127, 7, -128};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [7:0] x0 = '0, x1 = '0;
  logic out_valid;
  logic signed [OW-1:0] out_y0, out_y1;

  always #4 clk = ~clk;

  fir2p_sym_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x0(x0), .in_x1(x1),
    .out_valid(out_valid), .out_y0(out_y0), .out_y1(out_y1)
  );

  int hist[$];
  int exp_y0 = 0, exp_y1 = 0;
  bit exp_v = 1'b0;
  int tests = 0, fails = 0;
  bit armed = 1'b0, done = 1'b0;
  string req = "R1";

  function automatic int filt();
    int acc = 0;
    for (int i = 0; i < NT && i < hist.size(); i++) acc += H[i] * hist[i];
    return acc;
  endfunction

  // Behavioural reference: sample history, newest first.
  always @(posedge clk) begin
    if (rst) begin
      hist.delete();
      exp_v = 1'b0; exp_y0 = 0; exp_y1 = 0;
    end else if (in_valid) begin
      hist.push_front(int'(x0));
      exp_y0 = filt();
      hist.push_front(int'(x1));
      exp_y1 = filt();
      while (hist.size() > NT) void'(hist.pop_back());
      exp_v = 1'b1;
    end else begin
      exp_v = 1'b0;
    end
  end

  task automatic check(bit ok, string what, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      check(out_valid == exp_v, "out_valid (R3)", int'(out_valid), int'(exp_v));
      check(int'(out_y0) == exp_y0, "out_y0", int'(out_y0), exp_y0);
      check(int'(out_y1) == exp_y1, "out_y1", int'(out_y1), exp_y1);
    end
  end

  task automatic pair(bit v, int a, int b);
    @(negedge clk);
    in_valid = v; x0 = 8'(a); x1 = 8'(b);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk); armed = 1'b1;
    // R1: reset state
    req = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2: unit impulse on lane 0 exposes the whole response
    req = "R2";
    pair(1, 1, 0);
    repeat (5) pair(1, 0, 0);
    pair(0, 0, 0);
    // R6: impulse on lane 1 crosses into the next pair's lane 0
    req = "R6";
    pair(1, 0, 1);
    repeat (5) pair(1, 0, 0);
    // R2: odd values exercise the halving shift
    req = "R2";
    repeat (20) pair(1, $urandom_range(255) - 128, $urandom_range(255) - 128);
    // R4: gaps in the stream
    req = "R4";
    for (int k = 0; k < 200; k++)
      pair(($urandom_range(2) != 0), $urandom_range(255) - 128, $urandom_range(255) - 128);
    // R3: alternating valid
    req = "R3";
    for (int k = 0; k < 20; k++) pair(k % 2 == 0, 3 * k - 30, 50 - 4 * k);
    // R5: full scale, both signs
    req = "R5";
    repeat (8) pair(1, -128, -128);
    repeat (8) pair(1, 127, 127);
    repeat (8) pair(1, -128, 127);
    for (int k = 0; k < 8; k++) pair(1, (k % 2) ? 127 : -128, (k % 2) ? -128 : 127);
    // R1: reset in mid-stream clears state
    req = "R1";
    repeat (6) pair(1, $urandom_range(255) - 128, $urandom_range(255) - 128);
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); rst = 1'b0;
    pair(1, 5, -9);
    repeat (4) pair(1, 0, 0);
    pair(0, 0, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule